// File: doc/BRIEF.md
# Dual-Channel Converter Fault Latch

This block is the protection manager shared by two synchronous buck channels. It takes per-channel comparator flags from the analog side (output too high, output collapsed, output below its hold level, current limit reached) together with the high-side and low-side gate requests of each channel's modulator. From these it decides what actually reaches the gate drivers. Faults are remembered in a small state machine that has three states: `ST_RUN`, `ST_OV_LATCH` and `ST_UV_LATCH`. An over-voltage on either rail shuts off both high-side switches and turns on both low-side switches to clamp the outputs. A sustained short, seen as eight current-limited cycles in a row while the output has collapsed, turns both channels off. This count is not taken during soft-start.

Once a fault is latched it holds until one of three events clears it. The first is the release of shutdown, seen as `shdn_n` going high. The second is a channel enable being dropped. The third is the input-supply-low flag. Shutdown, enables and supply-low pass through a two-stage synchronizer before any of them is used. The comparator flags and the cycle strobe are taken as already synchronous to `clk`. The transitions are as follows. `ST_RUN` goes to `ST_OV_LATCH` on an over-voltage. `ST_RUN` goes to `ST_UV_LATCH` on a counter trip. `ST_UV_LATCH` goes to `ST_OV_LATCH` on an over-voltage. Either latched state returns to `ST_RUN` on a clear event or while supply-low is held. A clear takes priority over entry into a latched state.

Top module: `fpl_fault_latch`

## Requirements
- R1: While reset is asserted, and right after it, every gate drive output and both latched flags are 0.
- R2: An over-voltage flag on either channel, with no clear pending, sets `ov_latched` at the next clock edge. While shutdown is released, both `hs_drv` bits are then 0 and both `ls_drv` bits are 1.
- R3: A channel's counter counts only on cycles where `cyc_strobe` is 1 and both `ilim` and `uv` of that channel are 1. At the 8th such consecutive strobe, `uv_latched` becomes 1 on that strobe's edge and both `hs_drv` bits go to 0.
- R4: A strobe where a channel lacks `ilim` or `uv` sets that channel's count back to zero. Seven hits, then a miss, then seven more hits do not latch.
- R5: While a channel's `ss_act` is 1, its strobes never count toward the latch-off.
- R6: A channel that is disabled, or any channel while `uv_latched` is set, drives `hs_drv`=0 and `ls_drv` equal to its `lsh` flag (bit 0 is channel 0 in all vectors).
- R7: Two edges after `shdn_n` goes low, all gate outputs are 0 regardless of latch state.
- R8: A latch survives shutdown and clears three edges after `shdn_n` rises.
- R9: A 1-to-0 change of either `en` bit clears a latch three edges later.
- R10: Supply-low clears any latch three edges after it rises. While it stays high, nothing latches.
- R11: In `ST_RUN` with the channel enabled and shutdown released, `hs_drv` follows `hs_req`, and `ls_drv` follows `ls_req` except that it is 0 whenever `hs_req` is 1.
- R12: Over-voltage wins over under-voltage. An over-voltage during `ST_UV_LATCH` moves to `ST_OV_LATCH`, so `uv_latched` drops and `ov_latched` rises. The two flags are never both 1.
- R13: With no clear event, a latch remains after its cause goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shdn_n | input | 1 | Shutdown, active low (asynchronous) |
| supply_low | input | 1 | Input supply below restart level (asynchronous) |
| en | input | NCH | Per-channel enable (asynchronous) |
| ss_act | input | NCH | Per-channel soft-start in progress |
| cyc_strobe | input | 1 | One-cycle pulse per switching period |
| ov | input | NCH | Output above 120 % of nominal |
| uv | input | NCH | Output below 20 % of nominal |
| lsh | input | NCH | Output below 93 % of nominal |
| ilim | input | NCH | Current limit reached this period |
| hs_req | input | NCH | High-side gate request from modulator |
| ls_req | input | NCH | Low-side gate request from modulator |
| hs_drv | output | NCH | High-side gate drive |
| ls_drv | output | NCH | Low-side gate drive |
| ov_latched | output | 1 | Over-voltage latch state |
| uv_latched | output | 1 | Under-voltage latch state |

## Verification
The gate outputs are combinational from the state register and the inputs. Pass-through and off-state results are therefore due in the same cycle as the request, and the bench samples them shortly after driving on the falling edge. An over-voltage or the eighth counted strobe changes the state one edge after it is applied. Shutdown forcing appears after two edges, through the synchronizer. Clears from shutdown release, enable drop or supply-low appear after three edges, because one edge detector follows the synchronizer. The bench drives on falling edges and checks after exactly those counts of edges. Boundary checks are taken at count seven and count eight.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_OV_LATCH = 2'd1,
        ST_UV_LATCH = 2'd2
    } fpl_state_e;
endpackage

// File: rtl/fpl_sync.sv
module fpl_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fpl_uv_counter.sv
module fpl_uv_counter #(
    parameter int TRIP_CNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic strobe,
    input  logic ilim,
    input  logic uv,
    input  logic ss_act,
    output logic trip
);
    localparam int CW = $clog2(TRIP_CNT + 1);
    localparam logic [CW-1:0] LAST = CW'(TRIP_CNT - 1);

    logic [CW-1:0] cnt;
    logic          hit;

    assign hit  = ilim && uv && !ss_act;
    assign trip = run && strobe && hit && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (strobe) begin
            if (!hit)
                cnt <= '0;
            else if (cnt != CW'(TRIP_CNT))
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fpl_gate_mux.sv
module fpl_gate_mux (
    input  logic shdn_s,
    input  logic ov_lat,
    input  logic uv_lat,
    input  logic en_s,
    input  logic hs_req,
    input  logic ls_req,
    input  logic lsh,
    output logic hs,
    output logic ls
);
    always_comb begin
        if (!shdn_s) begin
            hs = 1'b0;
            ls = 1'b0;
        end else if (ov_lat) begin
            hs = 1'b0;
            ls = 1'b1;
        end else if (uv_lat || !en_s) begin
            hs = 1'b0;
            ls = lsh;
        end else begin
            hs = hs_req;
            ls = ls_req && !hs_req;
        end
    end
endmodule

// File: rtl/fpl_fault_latch.sv
module fpl_fault_latch
    import fpl_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int TRIP_CNT    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shdn_n,
    input  logic           supply_low,
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] ss_act,
    input  logic           cyc_strobe,
    input  logic [NCH-1:0] ov,
    input  logic [NCH-1:0] uv,
    input  logic [NCH-1:0] lsh,
    input  logic [NCH-1:0] ilim,
    input  logic [NCH-1:0] hs_req,
    input  logic [NCH-1:0] ls_req,
    output logic [NCH-1:0] hs_drv,
    output logic [NCH-1:0] ls_drv,
    output logic           ov_latched,
    output logic           uv_latched
);
    localparam int SW = NCH + 2;

    logic [SW-1:0]  sync_in;
    logic [SW-1:0]  sync_out;
    logic           shdn_s;
    logic           sup_low_s;
    logic [NCH-1:0] en_s;
    logic           shdn_q;
    logic [NCH-1:0] en_q;
    logic           clr_evt;
    logic [NCH-1:0] trip;
    logic           run;

    fpl_state_e state, state_nx;

    assign sync_in = {supply_low, en, shdn_n};

    fpl_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sync_in),
        .q    (sync_out)
    );

    assign shdn_s    = sync_out[0];
    assign en_s      = sync_out[NCH:1];
    assign sup_low_s = sync_out[NCH+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shdn_q <= 1'b0;
            en_q   <= '0;
        end else begin
            shdn_q <= shdn_s;
            en_q   <= en_s;
        end
    end

    assign clr_evt = (shdn_s && !shdn_q) || (|(en_q & ~en_s));
    assign run     = (state == ST_RUN) && !sup_low_s;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        fpl_uv_counter #(.TRIP_CNT(TRIP_CNT)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .strobe(cyc_strobe),
            .ilim  (ilim[c]),
            .uv    (uv[c]),
            .ss_act(ss_act[c]),
            .trip  (trip[c])
        );

        fpl_gate_mux u_mux (
            .shdn_s(shdn_s),
            .ov_lat(ov_latched),
            .uv_lat(uv_latched),
            .en_s  (en_s[c]),
            .hs_req(hs_req[c]),
            .ls_req(ls_req[c]),
            .lsh   (lsh[c]),
            .hs    (hs_drv[c]),
            .ls    (ls_drv[c])
        );
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (sup_low_s || clr_evt) state_nx = ST_RUN;
                else if (|ov)             state_nx = ST_OV_LATCH;
                else if (|trip)           state_nx = ST_UV_LATCH;
            end
            ST_OV_LATCH: begin
                if (sup_low_s || clr_evt) state_nx = ST_RUN;
            end
            ST_UV_LATCH: begin
                if (sup_low_s || clr_evt) state_nx = ST_RUN;
                else if (|ov)             state_nx = ST_OV_LATCH;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // status outputs
    always_comb begin
        ov_latched = 1'b0;
        uv_latched = 1'b0;
        unique case (state)
            ST_OV_LATCH: ov_latched = 1'b1;
            ST_UV_LATCH: uv_latched = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/fpl_fault_latch_chk.sv
module fpl_fault_latch_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] ov,
    input logic [NCH-1:0] uv,
    input logic [NCH-1:0] ilim,
    input logic [NCH-1:0] ss_act,
    input logic           cyc_strobe,
    input logic [NCH-1:0] hs_drv,
    input logic [NCH-1:0] ls_drv,
    input logic           ov_latched,
    input logic           uv_latched,
    input logic           shdn_s,
    input logic           sup_low_s,
    input logic           clr_evt
);
    AST_OV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (|ov && !clr_evt && !sup_low_s) |=> ov_latched); // R2
    AST_OV_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_latched && shdn_s) |-> (hs_drv == '0 && ls_drv == '1)); // R2
    AST_UV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uv_latched) |-> $past(cyc_strobe && |(ilim & uv & ~ss_act))); // R5
    AST_SHDN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_s |-> (hs_drv == '0 && ls_drv == '0)); // R7
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (!ov_latched && !uv_latched)); // R8
    AST_SUPLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sup_low_s |=> (!ov_latched && !uv_latched)); // R10
    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_drv & ls_drv) == '0); // R11
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ov_latched && uv_latched)); // R12
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_latched && !clr_evt && !sup_low_s) |=> ov_latched); // R13
endmodule

bind fpl_fault_latch fpl_fault_latch_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ov        (ov),
    .uv        (uv),
    .ilim      (ilim),
    .ss_act    (ss_act),
    .cyc_strobe(cyc_strobe),
    .hs_drv    (hs_drv),
    .ls_drv    (ls_drv),
    .ov_latched(ov_latched),
    .uv_latched(uv_latched),
    .shdn_s    (shdn_s),
    .sup_low_s (sup_low_s),
    .clr_evt   (clr_evt)
);

// File: tb/tb_fpl_fault_latch.sv
`timescale 1ns/1ps
module tb_fpl_fault_latch;
    logic       clk = 1'b0;
    logic       rst_n, shdn_n, supply_low, cyc_strobe;
    logic [1:0] en, ss_act, ov, uv, lsh, ilim, hs_req, ls_req;
    logic [1:0] hs_drv, ls_drv;
    logic       ov_latched, uv_latched;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    fpl_fault_latch dut (.*);

    // {hs_req, ls_req, lsh, exp_hs, exp_ls}; ch0 enabled, ch1 disabled
    localparam logic [9:0] VEC [8] = '{
        {2'b00, 2'b00, 2'b00, 2'b00, 2'b00},
        {2'b01, 2'b00, 2'b00, 2'b01, 2'b00},
        {2'b00, 2'b01, 2'b00, 2'b00, 2'b01},
        {2'b01, 2'b01, 2'b00, 2'b01, 2'b00},
        {2'b10, 2'b10, 2'b00, 2'b00, 2'b00},
        {2'b10, 2'b00, 2'b10, 2'b00, 2'b10},
        {2'b11, 2'b11, 2'b11, 2'b01, 2'b10},
        {2'b00, 2'b01, 2'b11, 2'b00, 2'b11}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(input logic [1:0] il, input logic [1:0] u);
        cyc_strobe = 1'b1; ilim = il; uv = u;
        @(negedge clk);
        cyc_strobe = 1'b0; ilim = 2'b00; uv = 2'b00;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; shdn_n = 0; supply_low = 0; cyc_strobe = 0;
        en = 0; ss_act = 0; ov = 0; uv = 0; lsh = 0; ilim = 0;
        hs_req = 2'b11; ls_req = 2'b11;
        cyc(3);
        chk("R1 drives", {4'b0, hs_drv, ls_drv}, 8'h00);
        chk("R1 flags", {6'b0, ov_latched, uv_latched}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", {2'b0, ov_latched, uv_latched, hs_drv, ls_drv}, 8'h00);
        shdn_n = 1; en = 2'b01;
        cyc(4);

        // table walk: pass-through and off-state channel
        foreach (VEC[k]) begin
            hs_req = VEC[k][9:8]; ls_req = VEC[k][7:6]; lsh = VEC[k][5:4];
            #1;
            chk($sformatf("R11/R6 vec%0d", k), {4'b0, hs_drv, ls_drv},
                {4'b0, VEC[k][3:2], VEC[k][1:0]});
            @(negedge clk);
        end

        // over-voltage
        en = 2'b11; hs_req = 2'b11; ls_req = 2'b00; lsh = 2'b00;
        cyc(4);
        ov = 2'b10;
        @(negedge clk);
        chk("R2 ov latch", {4'b0, ov_latched, uv_latched, hs_drv}, 8'h08);
        chk("R2 ls forced", {6'b0, ls_drv}, 8'h03);
        ov = 2'b00;
        cyc(3);
        chk("R13 hold", {7'b0, ov_latched}, 8'h01);
        en = 2'b10;
        cyc(3);
        chk("R9 en clear", {7'b0, ov_latched}, 8'h00);
        en = 2'b11;
        cyc(4);

        // under-voltage count on ch0
        lsh = 2'b01;
        for (int i = 0; i < 7; i++) strobe(2'b01, 2'b01);
        chk("R3 seven no latch", {7'b0, uv_latched}, 8'h00);
        cyc(2);
        strobe(2'b01, 2'b01);
        chk("R3 eighth latch", {4'b0, uv_latched, ov_latched, hs_drv}, 8'h08);
        chk("R6 uv ls=lsh", {6'b0, ls_drv}, 8'h01);
        shdn_n = 0;
        cyc(3);
        chk("R7 shutdown off", {4'b0, hs_drv, ls_drv}, 8'h00);
        chk("R8 persists in shutdown", {7'b0, uv_latched}, 8'h01);
        shdn_n = 1;
        cyc(3);
        chk("R8 release clears", {7'b0, uv_latched}, 8'h00);
        cyc(2);

        // R4 break resets count
        for (int i = 0; i < 7; i++) strobe(2'b01, 2'b01);
        strobe(2'b00, 2'b01);
        for (int i = 0; i < 7; i++) strobe(2'b01, 2'b01);
        chk("R4 broken run", {7'b0, uv_latched}, 8'h00);
        strobe(2'b01, 2'b01);
        chk("R4 resumed run", {7'b0, uv_latched}, 8'h01);

        // R12 ov over uv
        ov = 2'b01;
        @(negedge clk);
        ov = 2'b00;
        chk("R12 upgrade", {6'b0, ov_latched, uv_latched}, 8'h02);

        // R10 supply-low
        supply_low = 1;
        cyc(3);
        chk("R10 clear", {6'b0, ov_latched, uv_latched}, 8'h00);
        ov = 2'b11;
        cyc(2);
        chk("R10 held off", {6'b0, ov_latched, uv_latched}, 8'h00);
        ov = 2'b00; supply_low = 0;
        cyc(4);

        // R5 soft-start mask, then ch1 counts
        ss_act = 2'b01;
        for (int i = 0; i < 10; i++) strobe(2'b01, 2'b01);
        chk("R5 masked", {7'b0, uv_latched}, 8'h00);
        ss_act = 2'b00;
        for (int i = 0; i < 8; i++) strobe(2'b10, 2'b10);
        chk("R3 ch1 latch", {7'b0, uv_latched}, 8'h01);
        en = 2'b01;
        cyc(3);
        chk("R9 ch1 en clear", {7'b0, uv_latched}, 8'h00);

        finish_run();
    end
endmodule